// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles a host issues to a byte-wide flash-style memory. Each write carries a 15-bit command address and a data byte. The decoder tracks the fixed-address unlock sequences and turns each completed sequence into a mode change or a command. It can open a programming window, switch identification mode on or off, lock the lower or upper boot block, or request an erase of the whole array.

While the programming window is open, every write is passed on as a byte load. The window closes when the array controller reports that the program cycle has ended. A write that belongs to no sequence is flagged as a stray write, so the controller can start its write timer without storing data. The two lock bits are sticky. While either lock bit is set, an erase request is refused.

Top module: `fcsd_decoder`

## Requirements
- R1: After reset, all outputs are 0: `prog_en`, `id_mode`, `lock_lo`, `lock_hi` and the four one-cycle pulses.
- R2: Three consecutive command writes open the programming window: data AA at address 5555, then data 55 at address 2AAA, then data A0 at address 5555. `prog_en` is 1 from the clock edge that takes the third write.
- R3: While `prog_en` is 1 and `prog_done` is 0, every write pulses `load_stb` for one cycle one clock later. Such a write is never treated as a command, even if it is AA at 5555.
- R4: `prog_en` returns to 0 on the edge where `prog_done` is 1, so each new programming window needs a new three-write unlock.
- R5: The two-write prefix AA/5555, 55/2AAA followed by 90 at 5555 sets `id_mode`. The same prefix followed by F0 at 5555 clears it.
- R6: The address is matched on all 15 bits and the data on the full 8 bits. A write that does not match the cycle expected next, or a command write with no sequence in progress, returns the tracker to idle and pulses `stray_wr` one cycle later.
- R7: A mismatching write that is itself AA at 5555 does not pulse `stray_wr`. It counts as the first cycle of a new sequence.
- R8: The six-write sequence AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 10/5555 pulses `erase_go` when neither lock bit is set.
- R9: The sequence AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 40/5555 is followed by a final write that picks the block. Data 00 at address 0000 sets `lock_lo`. Data FF at address 7FFF sets `lock_hi`. Any other final write is a stray write.
- R10: If `lock_lo` or `lock_hi` is set when the erase sequence completes, the decoder pulses `erase_block` instead of `erase_go`.
- R11: Once set, `lock_lo` and `lock_hi` stay set until reset, whatever commands follow.
- R12: When `prog_done` and a write occur in the same cycle, the window closes and the write is decoded as a command write, not as a byte load. The decoder raises at most one of the four pulses in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One write cycle is present this clock |
| wr_addr | input | 15 | Command address of the write |
| wr_data | input | 8 | Data byte of the write |
| prog_done | input | 1 | The array controller has finished a program cycle |
| prog_en | output | 1 | The programming window is open |
| id_mode | output | 1 | Identification mode is active |
| lock_lo | output | 1 | The lower boot block is locked |
| lock_hi | output | 1 | The upper boot block is locked |
| erase_go | output | 1 | One-cycle pulse: an erase of the whole array is accepted |
| erase_block | output | 1 | One-cycle pulse: an erase is refused because a block is locked |
| stray_wr | output | 1 | One-cycle pulse: a write matched no expected cycle |
| load_stb | output | 1 | One-cycle pulse: a write was accepted as a byte load |

## Verification
Two functions can meet in one cycle: the end-of-program report and a new host write. The bench opens a window and then drives AA at 5555 in the same cycle as `prog_done`. It then expects `prog_en` to drop with no `load_stb` and no `stray_wr`. Next, 55/2AAA and A0/5555 must reopen the window. This shows the colliding write was taken as the first cycle of a new unlock and was not lost as a byte load. A second overlap is checked as well: an abort and a restart carried by the same write, where AA at 5555 arrives in the middle of a sequence.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;
  parameter int CMD_AW = 15;
  parameter int CMD_DW = 8;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [CMD_AW-1:0] LO_TARGET  = '0;
  localparam logic [CMD_AW-1:0] HI_TARGET  = '1;

  localparam logic [CMD_DW-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [CMD_DW-1:0] KEY_DATA_B = 8'h55;
  localparam logic [CMD_DW-1:0] OP_PROG    = 8'hA0;
  localparam logic [CMD_DW-1:0] OP_ID_ON   = 8'h90;
  localparam logic [CMD_DW-1:0] OP_ID_OFF  = 8'hF0;
  localparam logic [CMD_DW-1:0] OP_EXTEND  = 8'h80;
  localparam logic [CMD_DW-1:0] OP_LOCK    = 8'h40;
  localparam logic [CMD_DW-1:0] OP_ERASE   = 8'h10;
  localparam logic [CMD_DW-1:0] LO_CODE    = 8'h00;
  localparam logic [CMD_DW-1:0] HI_CODE    = 8'hFF;

  typedef enum logic [2:0] {
    TS_IDLE, TS_KEY1, TS_KEY2, TS_EXT1, TS_EXT2, TS_EXT3, TS_PICK
  } trk_state_t;

  typedef struct packed {
    logic key_a;
    logic key_b;
    logic op_prog;
    logic op_id_on;
    logic op_id_off;
    logic op_extend;
    logic op_lock;
    logic op_erase;
    logic pick_lo;
    logic pick_hi;
  } cyc_class_t;

  function automatic logic cyc_hit(input logic [CMD_AW-1:0] a, input logic [CMD_DW-1:0] d,
                                   input logic [CMD_AW-1:0] ea, input logic [CMD_DW-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/fcsd_classify.sv
module fcsd_classify
  import fcsd_pkg::*;
(
  input  logic [CMD_AW-1:0] addr,
  input  logic [CMD_DW-1:0] data,
  output cyc_class_t        cls
);
  always_comb begin
    cls.key_a     = cyc_hit(addr, data, KEY_ADDR_A, KEY_DATA_A);
    cls.key_b     = cyc_hit(addr, data, KEY_ADDR_B, KEY_DATA_B);
    cls.op_prog   = cyc_hit(addr, data, KEY_ADDR_A, OP_PROG);
    cls.op_id_on  = cyc_hit(addr, data, KEY_ADDR_A, OP_ID_ON);
    cls.op_id_off = cyc_hit(addr, data, KEY_ADDR_A, OP_ID_OFF);
    cls.op_extend = cyc_hit(addr, data, KEY_ADDR_A, OP_EXTEND);
    cls.op_lock   = cyc_hit(addr, data, KEY_ADDR_A, OP_LOCK);
    cls.op_erase  = cyc_hit(addr, data, KEY_ADDR_A, OP_ERASE);
    cls.pick_lo   = cyc_hit(addr, data, LO_TARGET, LO_CODE);
    cls.pick_hi   = cyc_hit(addr, data, HI_TARGET, HI_CODE);
  end
endmodule

// File: rtl/fcsd_tracker.sv
module fcsd_tracker
  import fcsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  cyc_class_t cls,
  output logic       ev_prog,
  output logic       ev_id_on,
  output logic       ev_id_off,
  output logic       ev_erase,
  output logic       ev_lock_lo,
  output logic       ev_lock_hi,
  output logic       ev_abort,
  output logic       ev_stray
);
  trk_state_t st, st_nxt;

  always_comb begin
    st_nxt     = st;
    ev_prog    = 1'b0;
    ev_id_on   = 1'b0;
    ev_id_off  = 1'b0;
    ev_erase   = 1'b0;
    ev_lock_lo = 1'b0;
    ev_lock_hi = 1'b0;
    ev_abort   = 1'b0;
    if (cmd_wr) begin
      case (st)
        TS_IDLE: if (cls.key_a) st_nxt = TS_KEY1; else ev_abort = 1'b1;
        TS_KEY1: if (cls.key_b) st_nxt = TS_KEY2; else ev_abort = 1'b1;
        TS_KEY2: begin
          st_nxt = TS_IDLE;
          if (cls.op_prog)        ev_prog   = 1'b1;
          else if (cls.op_id_on)  ev_id_on  = 1'b1;
          else if (cls.op_id_off) ev_id_off = 1'b1;
          else if (cls.op_extend) st_nxt    = TS_EXT1;
          else                    ev_abort  = 1'b1;
        end
        TS_EXT1: if (cls.key_a) st_nxt = TS_EXT2; else ev_abort = 1'b1;
        TS_EXT2: if (cls.key_b) st_nxt = TS_EXT3; else ev_abort = 1'b1;
        TS_EXT3: begin
          st_nxt = TS_IDLE;
          if (cls.op_lock)       st_nxt   = TS_PICK;
          else if (cls.op_erase) ev_erase = 1'b1;
          else                   ev_abort = 1'b1;
        end
        TS_PICK: begin
          st_nxt = TS_IDLE;
          if (cls.pick_lo)      ev_lock_lo = 1'b1;
          else if (cls.pick_hi) ev_lock_hi = 1'b1;
          else                  ev_abort   = 1'b1;
        end
        default: ev_abort = 1'b1;
      endcase
      if (ev_abort) st_nxt = cls.key_a ? TS_KEY1 : TS_IDLE;
    end
  end

  assign ev_stray = ev_abort & ~cls.key_a;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= TS_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/fcsd_modes.sv
module fcsd_modes (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_done,
  input  logic ld_wr,
  input  logic ev_prog,
  input  logic ev_id_on,
  input  logic ev_id_off,
  input  logic ev_erase,
  input  logic ev_lock_lo,
  input  logic ev_lock_hi,
  input  logic ev_stray,
  output logic prog_en,
  output logic id_mode,
  output logic lock_lo,
  output logic lock_hi,
  output logic erase_go,
  output logic erase_block,
  output logic stray_wr,
  output logic load_stb
);
  logic any_lock;
  assign any_lock = lock_lo | lock_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_en     <= 1'b0;
      id_mode     <= 1'b0;
      lock_lo     <= 1'b0;
      lock_hi     <= 1'b0;
      erase_go    <= 1'b0;
      erase_block <= 1'b0;
      stray_wr    <= 1'b0;
      load_stb    <= 1'b0;
    end else begin
      if (ev_prog)        prog_en <= 1'b1;
      else if (prog_done) prog_en <= 1'b0;
      if (ev_id_on)       id_mode <= 1'b1;
      else if (ev_id_off) id_mode <= 1'b0;
      if (ev_lock_lo) lock_lo <= 1'b1;
      if (ev_lock_hi) lock_hi <= 1'b1;
      erase_go    <= ev_erase & ~any_lock;
      erase_block <= ev_erase & any_lock;
      stray_wr    <= ev_stray;
      load_stb    <= ld_wr;
    end
  end
endmodule

// File: rtl/fcsd_decoder.sv
module fcsd_decoder
  import fcsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [CMD_DW-1:0] wr_data,
  input  logic              prog_done,
  output logic              prog_en,
  output logic              id_mode,
  output logic              lock_lo,
  output logic              lock_hi,
  output logic              erase_go,
  output logic              erase_block,
  output logic              stray_wr,
  output logic              load_stb
);
  cyc_class_t cls;
  logic window_live, cmd_wr, ld_wr;
  logic ev_prog, ev_id_on, ev_id_off, ev_erase, ev_lock_lo, ev_lock_hi, ev_abort, ev_stray;

  // a window that closes this cycle no longer captures the write
  assign window_live = prog_en & ~prog_done;
  assign ld_wr       = wr_en & window_live;
  assign cmd_wr      = wr_en & ~window_live;

  fcsd_classify u_cls (.addr(wr_addr), .data(wr_data), .cls(cls));

  fcsd_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cls(cls),
    .ev_prog(ev_prog), .ev_id_on(ev_id_on), .ev_id_off(ev_id_off),
    .ev_erase(ev_erase), .ev_lock_lo(ev_lock_lo), .ev_lock_hi(ev_lock_hi),
    .ev_abort(ev_abort), .ev_stray(ev_stray)
  );

  fcsd_modes u_mod (
    .clk(clk), .rst_n(rst_n), .prog_done(prog_done), .ld_wr(ld_wr),
    .ev_prog(ev_prog), .ev_id_on(ev_id_on), .ev_id_off(ev_id_off),
    .ev_erase(ev_erase), .ev_lock_lo(ev_lock_lo), .ev_lock_hi(ev_lock_hi),
    .ev_stray(ev_stray),
    .prog_en(prog_en), .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .erase_go(erase_go), .erase_block(erase_block), .stray_wr(stray_wr),
    .load_stb(load_stb)
  );
endmodule

// File: rtl/fcsd_checker.sv
module fcsd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic prog_done,
  input logic ev_prog,
  input logic ev_abort,
  input logic prog_en,
  input logic lock_lo,
  input logic lock_hi,
  input logic erase_go,
  input logic erase_block,
  input logic stray_wr,
  input logic load_stb
);
  assert_unlock_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> prog_en);

  assert_window_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !prog_done && wr_en) |=> (load_stb && !stray_wr));

  assert_done_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && prog_done && !ev_prog) |=> !prog_en);

  assert_abort_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !load_stb);

  assert_erase_needs_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> !$past(lock_lo || lock_hi));

  assert_lock_lo_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lo |=> lock_lo);

  assert_lock_hi_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hi |=> lock_hi);

  assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, erase_block, stray_wr, load_stb}));
endmodule

bind fcsd_decoder fcsd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .prog_done(prog_done),
  .ev_prog(ev_prog), .ev_abort(ev_abort), .prog_en(prog_en),
  .lock_lo(lock_lo), .lock_hi(lock_hi), .erase_go(erase_go),
  .erase_block(erase_block), .stray_wr(stray_wr), .load_stb(load_stb)
);

// File: tb/fcsd_decoder_tb.sv
module fcsd_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_done = 1'b0;
  logic prog_en, id_mode, lock_lo, lock_hi, erase_go, erase_block, stray_wr, load_stb;

  always #4 clk = ~clk;

  fcsd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done), .prog_en(prog_en), .id_mode(id_mode), .lock_lo(lock_lo),
    .lock_hi(lock_hi), .erase_go(erase_go), .erase_block(erase_block),
    .stray_wr(stray_wr), .load_stb(load_stb)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  // expected sticky state, maintained by the test sequence itself
  logic e_prog = 0, e_id = 0, e_lo = 0, e_hi = 0;

  function automatic logic [7:0] observed();
    return {prog_en, id_mode, lock_lo, lock_hi, erase_go, erase_block, stray_wr, load_stb};
  endfunction

  // pls = {erase_go, erase_block, stray_wr, load_stb}
  task automatic step(input logic w, input logic [14:0] a, input logic [7:0] d,
                      input logic dn, input logic [3:0] pls, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; prog_done = dn;
    it.exp = {e_prog, e_id, e_lo, e_hi, pls};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pre2(input string tag);
    step(1, 15'h5555, 8'hAA, 0, 4'b0000, tag);
    step(1, 15'h2AAA, 8'h55, 0, 4'b0000, tag);
  endtask

  task automatic pre5(input string tag);
    pre2(tag);
    step(1, 15'h5555, 8'h80, 0, 4'b0000, tag);
    pre2(tag);
  endtask

  // monitor: pops one expected item per applied cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        got = observed();
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (observed() !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset: got %b expected %b", observed(), 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 / R3 / R4 program window
    pre2("R2 prefix");
    e_prog = 1; step(1, 15'h5555, 8'hA0, 0, 4'b0000, "R2 unlock");
    step(1, 15'h0123, 8'h3C, 0, 4'b0001, "R3 load");
    step(1, 15'h5555, 8'hAA, 0, 4'b0001, "R3 key as load");
    step(0, 15'h0, 8'h0, 0, 4'b0000, "R3 idle");
    e_prog = 0; step(0, 15'h0, 8'h0, 1, 4'b0000, "R4 done closes");
    step(1, 15'h0124, 8'h11, 0, 4'b0010, "R4 write after close is stray");

    // R5 identification mode
    pre2("R5 prefix");
    e_id = 1; step(1, 15'h5555, 8'h90, 0, 4'b0000, "R5 id on");
    pre2("R5 prefix");
    e_id = 0; step(1, 15'h5555, 8'hF0, 0, 4'b0000, "R5 id off");

    // R6 full match on data and address
    pre2("R6 prefix");
    step(1, 15'h5555, 8'hA1, 0, 4'b0010, "R6 wrong data");
    step(1, 15'h5555, 8'hAA, 0, 4'b0000, "R6 key");
    step(1, 15'h2AAB, 8'h55, 0, 4'b0010, "R6 wrong addr");
    step(1, 15'h5555, 8'hA0, 0, 4'b0010, "R6 idle cmd stray");

    // R7 restart on key cycle mid-sequence
    step(1, 15'h5555, 8'hAA, 0, 4'b0000, "R7 first");
    step(1, 15'h5555, 8'hAA, 0, 4'b0000, "R7 restart no stray");
    step(1, 15'h2AAA, 8'h55, 0, 4'b0000, "R7 second");
    e_id = 1; step(1, 15'h5555, 8'h90, 0, 4'b0000, "R7 completes id on");

    // R8 erase while unlocked
    pre5("R8 prefix");
    step(1, 15'h5555, 8'h10, 0, 4'b1000, "R8 erase go");

    // R9 lock lower, plus a bad final write
    pre5("R9 prefix");
    step(1, 15'h5555, 8'h40, 0, 4'b0000, "R9 lock op");
    step(1, 15'h0001, 8'h00, 0, 4'b0010, "R9 bad target");
    pre5("R9 prefix");
    step(1, 15'h5555, 8'h40, 0, 4'b0000, "R9 lock op");
    e_lo = 1; step(1, 15'h0000, 8'h00, 0, 4'b0000, "R9 lock lower");

    // R10 erase refused
    pre5("R10 prefix");
    step(1, 15'h5555, 8'h10, 0, 4'b0100, "R10 erase refused");

    // R9 lock upper; R11 locks survive soft commands
    pre5("R9 prefix hi");
    step(1, 15'h5555, 8'h40, 0, 4'b0000, "R9 lock op hi");
    e_hi = 1; step(1, 15'h7FFF, 8'hFF, 0, 4'b0000, "R9 lock upper");
    pre2("R11 prefix");
    e_id = 0; step(1, 15'h5555, 8'hF0, 0, 4'b0000, "R11 id off keeps locks");
    step(1, 15'h7FFF, 8'h00, 0, 4'b0010, "R11 stray keeps locks");

    // R12 collision of program end and new write
    pre2("R12 prefix");
    e_prog = 1; step(1, 15'h5555, 8'hA0, 0, 4'b0000, "R12 open");
    e_prog = 0; step(1, 15'h5555, 8'hAA, 1, 4'b0000, "R12 done with key write");
    step(1, 15'h2AAA, 8'h55, 0, 4'b0000, "R12 second");
    e_prog = 1; step(1, 15'h5555, 8'hA0, 0, 4'b0000, "R12 reopened");
    e_prog = 0; step(1, 15'h0042, 8'h99, 1, 4'b0010, "R12 done with plain write");
    step(0, 15'h0, 8'h0, 0, 4'b0000, "R12 settle");

    @(posedge clk); #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule